// File: doc/BRIEF.md
# SPI EEPROM-Style Fuse Memory Front End

This block is a serial peripheral slave that gives a one-time-programmable byte array an interface modelled on small serial EEPROMs. Every SPI line is brought into the fast internal clock through synchronizers and edge detectors. The internal clock must run at least four times as fast as the serial clock. A transaction opens with an 8-bit command. The read and program commands then take a 24-bit address. Only the low address bits that select one of the configured words are kept.

A program command carries exactly one data byte and is honoured only if the write-enable latch is set. When chip-select rises it is turned into a request to the fuse array. The request is held until the array acknowledges it, and the device is busy for that whole time. A read command streams bytes from the addressed word onward and wraps the address as long as chip-select stays low. A status command returns the busy and write-enable flags. The array side is a plain combinational read port and a request/acknowledge program port.

Top module: `fuse_spi_front`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `spi_miso` is 0 and `pgm_req` is 0. A status read then returns 0x00, which means not busy and write disabled.
- R2: A program command (0x02) issued while the write-enable latch is clear raises no request, and the addressed word keeps its contents.
- R3: The write-enable command (0x06) sets the latch. Status bit 1 then reads 1.
- R4: A program command that ends with chip-select rising after exactly 8 data bits raises `pgm_req`. `pgm_addr` and `pgm_data` carry the address and the byte, both sent MSB first. The request, its address and its data stay constant until `pgm_ack`. Status bit 0 (busy) reads 1 for that whole time. All other status bits read 0.
- R5: Of the 24 address bits, only the low log2(NWORDS) bits select the word. Higher bits have no effect.
- R6: A read command (0x03) outputs the addressed byte MSB first. Each bit changes after a falling serial clock edge. While chip-select stays low, the following bytes stream out with the address incrementing and wrapping from the last word to word 0.
- R7: The write-disable command (0x04) clears the latch. A program command issued afterwards is ignored.
- R8: A program command that ends with chip-select rising after 7 or after 9 data bits raises no request.
- R9: An opcode that is not one of 0x02 to 0x06 is ignored for the rest of that chip-select period: `spi_miso` stays 0 and the latch is unchanged.
- R10: While busy, every command except status read (0x05) is ignored. This covers program, write disable and read.
- R11: `spi_miso` is 0 whenever chip-select is high.
- R12: A single write-enable stays valid for any number of later program commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_sck | input | 1 | Serial clock, data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| rd_addr | output | log2(NWORDS) | Read word address to the array |
| rd_data | input | 8 | Combinational read data from the array |
| pgm_req | output | 1 | Program request, held until acknowledged |
| pgm_addr | output | log2(NWORDS) | Word address to program |
| pgm_data | output | 8 | Byte to program |
| pgm_ack | input | 1 | One-cycle acknowledge from the array |

## Verification
The bench sends program commands that end after 7 and after 9 data bits. A design that counts bits loosely would commit a half-shifted or overrun byte on these. The bench also streams a read across the top of the address space. An off-by-one in the prefetch or increment would show up here as a repeated or skipped byte, or as a failure to wrap to word 0.

A long acknowledge delay holds the device busy while the bench sends a second program command and a write disable. A design that ignores busy would raise a second request or drop the latch. Finally, addresses with their high bits set are programmed and read back. A design that used those bits would land on the wrong word.

// File: rtl/fuse_spi_pkg.sv
package fuse_spi_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_WEN   = 8'h06;

    localparam logic [4:0] LAST_OPC_BIT  = 5'd7;
    localparam logic [4:0] LAST_ADDR_BIT = 5'd31;
    localparam logic [3:0] DATA_BITS     = 4'd8;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_RDOUT,
        PH_STAT,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_active;
        logic cs_rise;
        logic mosi;
    } spi_evt_t;

    function automatic logic [7:0] mk_status(input logic busy, input logic wen);
        return {6'b0, wen, busy};
    endfunction

endpackage

// File: rtl/fuse_spi_sync.sv
module fuse_spi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sck,
    input  logic                   spi_mosi,
    output fuse_spi_pkg::spi_evt_t evt
);
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] mosi_p;
    logic              cs_d;
    logic              sck_d;

    logic cs_s, sck_s, mosi_s;
    assign cs_s   = cs_p[STAGES-1];
    assign sck_s  = sck_p[STAGES-1];
    assign mosi_s = mosi_p[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p   <= '1;
            sck_p  <= '0;
            mosi_p <= '0;
            cs_d   <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_p   <= {cs_p[STAGES-2:0], spi_cs_n};
            sck_p  <= {sck_p[STAGES-2:0], spi_sck};
            mosi_p <= {mosi_p[STAGES-2:0], spi_mosi};
            cs_d   <= cs_s;
            sck_d  <= sck_s;
        end
    end

    always_comb begin
        evt.rise      = sck_s & ~sck_d & ~cs_s;
        evt.fall      = ~sck_s & sck_d & ~cs_s;
        evt.cs_active = ~cs_s;
        evt.cs_rise   = cs_s & ~cs_d;
        evt.mosi      = mosi_s;
    end
endmodule

// File: rtl/fuse_spi_tx.sv
module fuse_spi_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       fall,
    input  logic [7:0] byte_in,
    output logic       byte_taken,
    output logic       miso
);
    logic [6:0] sh_q;
    logic [2:0] idx_q;
    logic       miso_q;

    assign byte_taken = active & fall & (idx_q == 3'd0);
    assign miso       = miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            idx_q  <= '0;
            miso_q <= 1'b0;
        end else if (!active) begin
            idx_q  <= '0;
            miso_q <= 1'b0;
        end else if (fall) begin
            if (idx_q == 3'd0) begin
                miso_q <= byte_in[7];
                sh_q   <= byte_in[6:0];
            end else begin
                miso_q <= sh_q[6];
                sh_q   <= {sh_q[5:0], 1'b0};
            end
            idx_q <= idx_q + 3'd1;
        end
    end
endmodule

// File: rtl/fuse_spi_ctrl.sv
module fuse_spi_ctrl
    import fuse_spi_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_active,
    input  logic          cs_rise,
    input  logic          rise,
    input  logic          mosi,
    input  logic          byte_taken,
    input  logic          pgm_ack,
    output phase_t        phase,
    output logic [AW-1:0] rd_addr,
    output logic          pgm_req,
    output logic [AW-1:0] pgm_addr,
    output logic [7:0]    pgm_data,
    output logic          wen
);
    phase_t        phase_q;
    logic [4:0]    bitc_q;
    logic [6:0]    opc_q;
    logic          is_read_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    wdat_q;
    logic [3:0]    wcnt_q;
    logic          wen_q;
    logic          req_q;
    logic [AW-1:0] paddr_q;
    logic [7:0]    pdata_q;
    logic [7:0]    opcode;

    assign opcode   = {opc_q, mosi};
    assign phase    = phase_q;
    assign rd_addr  = addr_q;
    assign pgm_req  = req_q;
    assign pgm_addr = paddr_q;
    assign pgm_data = pdata_q;
    assign wen      = wen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_OPC;
            bitc_q    <= '0;
            opc_q     <= '0;
            is_read_q <= 1'b0;
            addr_q    <= '0;
            wdat_q    <= '0;
            wcnt_q    <= '0;
            wen_q     <= 1'b0;
            req_q     <= 1'b0;
            paddr_q   <= '0;
            pdata_q   <= '0;
        end else begin
            if (req_q && pgm_ack) begin
                req_q <= 1'b0;
            end
            if (!cs_active) begin
                phase_q <= PH_OPC;
                bitc_q  <= '0;
                wcnt_q  <= '0;
                if (cs_rise && phase_q == PH_WDATA && wcnt_q == DATA_BITS) begin
                    req_q   <= 1'b1;
                    paddr_q <= addr_q;
                    pdata_q <= wdat_q;
                end
            end else begin
                if (rise) begin
                    unique case (phase_q)
                        PH_OPC: begin
                            opc_q  <= opcode[6:0];
                            bitc_q <= bitc_q + 5'd1;
                            if (bitc_q == LAST_OPC_BIT) begin
                                if (opcode == OP_STAT) begin
                                    phase_q <= PH_STAT;
                                end else if (req_q) begin
                                    phase_q <= PH_SKIP;
                                end else begin
                                    unique case (opcode)
                                        OP_READ: begin
                                            is_read_q <= 1'b1;
                                            phase_q   <= PH_ADDR;
                                        end
                                        OP_PROG: begin
                                            is_read_q <= 1'b0;
                                            phase_q   <= wen_q ? PH_ADDR : PH_SKIP;
                                        end
                                        OP_WEN: begin
                                            wen_q   <= 1'b1;
                                            phase_q <= PH_SKIP;
                                        end
                                        OP_WDIS: begin
                                            wen_q   <= 1'b0;
                                            phase_q <= PH_SKIP;
                                        end
                                        default: phase_q <= PH_SKIP;
                                    endcase
                                end
                            end
                        end
                        PH_ADDR: begin
                            addr_q <= {addr_q[AW-2:0], mosi};
                            bitc_q <= bitc_q + 5'd1;
                            if (bitc_q == LAST_ADDR_BIT) begin
                                phase_q <= is_read_q ? PH_RDOUT : PH_WDATA;
                            end
                        end
                        PH_WDATA: begin
                            if (wcnt_q == DATA_BITS) begin
                                phase_q <= PH_SKIP;
                            end else begin
                                wdat_q <= {wdat_q[6:0], mosi};
                                wcnt_q <= wcnt_q + 4'd1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (byte_taken && phase_q == PH_RDOUT) begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fuse_spi_front.sv
module fuse_spi_front
    import fuse_spi_pkg::*;
#(
    parameter int unsigned NWORDS = 64,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          pgm_req,
    output logic [AW-1:0] pgm_addr,
    output logic [7:0]    pgm_data,
    input  logic          pgm_ack
);
    spi_evt_t   evt;
    phase_t     phase;
    logic       wen;
    logic       byte_taken;
    logic       tx_active;
    logic [7:0] tx_byte;

    fuse_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .evt      (evt)
    );

    fuse_spi_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (evt.cs_active),
        .cs_rise    (evt.cs_rise),
        .rise       (evt.rise),
        .mosi       (evt.mosi),
        .byte_taken (byte_taken),
        .pgm_ack    (pgm_ack),
        .phase      (phase),
        .rd_addr    (rd_addr),
        .pgm_req    (pgm_req),
        .pgm_addr   (pgm_addr),
        .pgm_data   (pgm_data),
        .wen        (wen)
    );

    assign tx_active = evt.cs_active && (phase == PH_RDOUT || phase == PH_STAT);
    assign tx_byte   = (phase == PH_RDOUT) ? rd_data : mk_status(pgm_req, wen);

    fuse_spi_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (tx_active),
        .fall       (evt.fall),
        .byte_in    (tx_byte),
        .byte_taken (byte_taken),
        .miso       (spi_miso)
    );
endmodule

// File: rtl/fuse_spi_chk.sv
module fuse_spi_chk #(
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_on,
    input logic          miso,
    input logic          pgm_req,
    input logic          pgm_ack,
    input logic [AW-1:0] pgm_addr,
    input logic [7:0]    pgm_data,
    input logic          wen
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && !pgm_ack) |=> pgm_req); // R4

    AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && pgm_ack) |=> !pgm_req); // R4

    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && !pgm_ack) |=> ($stable(pgm_addr) && $stable(pgm_data))); // R4

    AST_REQ_ON_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_req) |-> !cs_on); // R8

    AST_REQ_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_req) |-> $past(wen)); // R2

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_on |=> !miso); // R11
endmodule

bind fuse_spi_front fuse_spi_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_on    (evt.cs_active),
    .miso     (spi_miso),
    .pgm_req  (pgm_req),
    .pgm_ack  (pgm_ack),
    .pgm_addr (pgm_addr),
    .pgm_data (pgm_data),
    .wen      (wen)
);

// File: tb/sim_fuse_spi_front.sv
module sim_fuse_spi_front;
    localparam int HALF = 8;
    localparam int NW   = 64;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sck = 1'b0;
    logic          spi_mosi = 1'b0;
    logic          spi_miso;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          pgm_req;
    logic [AW-1:0] pgm_addr;
    logic [7:0]    pgm_data;
    logic          pgm_ack;

    int n_chk = 0;
    int n_fail = 0;
    int npgm = 0;
    int ack_delay = 20;
    int ack_cnt = 0;

    logic [7:0] mem [NW];

    always #2 clk = ~clk;

    fuse_spi_front #(.NWORDS(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rd_addr(rd_addr),
        .rd_data(rd_data), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .pgm_ack(pgm_ack)
    );

    assign rd_data = mem[rd_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_ack <= 1'b0;
            ack_cnt <= 0;
        end else begin
            pgm_ack <= 1'b0;
            if (pgm_req && !pgm_ack) begin
                if (ack_cnt >= ack_delay) begin
                    pgm_ack <= 1'b1;
                    mem[pgm_addr] = pgm_data;
                    npgm++;
                    ack_cnt <= 0;
                end else begin
                    ack_cnt <= ack_cnt + 1;
                end
            end
        end
    end

    // stimulus/expected: {24-bit address, data byte, expected word index (8 bits)}
    localparam logic [39:0] VEC [6] = '{
        {24'h000003, 8'h11, 8'h03},
        {24'hABCD07, 8'h22, 8'h07},
        {24'hFFFF3F, 8'h33, 8'h3F},
        {24'h000120, 8'h44, 8'h20},
        {24'h7F0000, 8'h55, 8'h00},
        {24'h00002A, 8'h66, 8'h2A}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_io(input logic b, output logic r);
        spi_mosi = b;
        wait_clk(HALF);
        r = spi_miso;
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            bit_io(tx[i], rx[i]);
        end
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo();
        xfer(op, d);
        cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] d;
        cs_lo();
        xfer(8'h05, d);
        xfer(8'h00, st);
        cs_hi();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] d;
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic wr(input logic [23:0] a, input logic [7:0] data, input int nbits);
        logic [7:0] d;
        logic       r;
        cs_lo();
        xfer(8'h02, d);
        send_addr(a);
        for (int i = 0; i < nbits; i++) begin
            bit_io((i < 8) ? data[7 - i] : 1'b0, r);
        end
        cs_hi();
    endtask

    task automatic rd1(input logic [23:0] a, output logic [7:0] v);
        logic [7:0] d;
        cs_lo();
        xfer(8'h03, d);
        send_addr(a);
        xfer(8'h00, v);
        cs_hi();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && pgm_req; i++) wait_clk(1);
    endtask

    task automatic wait_req(output logic seen);
        seen = pgm_req;
        for (int i = 0; i < 200 && !seen; i++) begin
            wait_clk(1);
            seen = pgm_req;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] st, v, d;
        logic       seen, r;
        int         base;
        for (int i = 0; i < NW; i++) mem[i] = 8'h5A ^ 8'(i);

        wait_clk(5);
        check("R1 miso after reset", 32'(spi_miso), 0);
        check("R1 req after reset", 32'(pgm_req), 0);
        rst_n = 1'b1;
        wait_clk(5);
        rdsr(st);
        check("R1 status after reset", 32'(st), 32'h00);

        // R2: program without write enable
        wr(24'h000010, 8'hC3, 8);
        wait_clk(100);
        check("R2 no request without enable", 32'(npgm), 0);
        rd1(24'h000010, v);
        check("R2 word unchanged", 32'(v), 32'h4A);

        // R3: write enable
        cmd1(8'h06);
        rdsr(st);
        check("R3 status after enable", 32'(st), 32'h02);

        // R4 R5 R12: table of programs after a single enable
        for (int k = 0; k < 6; k++) begin
            base = npgm;
            wr(VEC[k][39:16], VEC[k][15:8], 8);
            wait_req(seen);
            check("R4 request raised", 32'(seen), 1);
            check("R5 request address", 32'(pgm_addr), 32'(VEC[k][5:0]));
            check("R4 request data", 32'(pgm_data), 32'(VEC[k][15:8]));
            wait_idle();
            wait_clk(4);
            check("R4 one commit", 32'(npgm - base), 1);
            rd1({16'h0, VEC[k][7:0]}, v);
            check("R5 readback", 32'(v), 32'(VEC[k][15:8]));
            rdsr(st);
            check("R12 enable persists", 32'(st), 32'h02);
        end

        // R4 R10: busy behaviour
        ack_delay = 5000;
        base = npgm;
        wr(24'h000011, 8'h77, 8);
        rdsr(st);
        check("R4 status busy", 32'(st), 32'h03);
        wr(24'h000012, 8'h99, 8);
        cmd1(8'h04);
        cs_lo();
        xfer(8'h03, d);
        send_addr(24'h000013);
        xfer(8'h00, v);
        cs_hi();
        check("R10 read ignored while busy", 32'(v), 0);
        rdsr(st);
        check("R10 disable ignored while busy", 32'(st), 32'h03);
        wait_idle();
        wait_clk(4);
        check("R10 only one commit", 32'(npgm - base), 1);
        ack_delay = 20;
        rd1(24'h000012, v);
        check("R10 second program ignored", 32'(v), 32'h48);
        rd1(24'h000011, v);
        check("R4 busy-time program landed", 32'(v), 32'h77);

        // R6: streaming read across wrap
        cs_lo();
        xfer(8'h03, d);
        send_addr(24'h00003E);
        xfer(8'h00, v); check("R6 stream byte 0", 32'(v), 32'h64);
        xfer(8'h00, v); check("R6 stream byte 1", 32'(v), 32'h33);
        xfer(8'h00, v); check("R6 stream wrap byte", 32'(v), 32'h55);
        xfer(8'h00, v); check("R6 stream after wrap", 32'(v), 32'h5B);
        cs_hi();

        // R8: wrong data length
        base = npgm;
        wr(24'h000005, 8'hF0, 7);
        wr(24'h000006, 8'hF0, 9);
        wait_clk(100);
        check("R8 no commit on 7 or 9 bits", 32'(npgm - base), 0);
        rd1(24'h000005, v);
        check("R8 word 5 unchanged", 32'(v), 32'h5F);
        rd1(24'h000006, v);
        check("R8 word 6 unchanged", 32'(v), 32'h5C);

        // R9: unknown opcodes
        cs_lo();
        xfer(8'hA5, d);
        xfer(8'h00, v);
        xfer(8'h00, d);
        cs_hi();
        check("R9 miso quiet after unknown opcode", 32'({v, d}), 0);
        cmd1(8'h00);
        rdsr(st);
        check("R9 latch unchanged", 32'(st), 32'h02);

        // R7: write disable
        cmd1(8'h04);
        rdsr(st);
        check("R7 status after disable", 32'(st), 32'h00);
        base = npgm;
        wr(24'h000008, 8'hEE, 8);
        wait_clk(100);
        check("R7 program ignored", 32'(npgm - base), 0);
        rd1(24'h000008, v);
        check("R7 word unchanged", 32'(v), 32'h52);

        // R11: clock toggling with chip-select high
        seen = 1'b0;
        spi_mosi = 1'b1;
        for (int i = 0; i < 16; i++) begin
            spi_sck = ~spi_sck;
            wait_clk(HALF);
            if (spi_miso) seen = 1'b1;
        end
        spi_sck = 1'b0;
        check("R11 miso low while deselected", 32'(seen), 0);

        // R1: reset clears enable
        cmd1(8'h06);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        rdsr(st);
        check("R1 reset clears enable", 32'(st), 32'h00);
        r = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule